// File: doc/BRIEF.md
# Time-Shared Multichannel Sine/Cosine Oscillator

This block is one oscillator datapath shared in time by up to eight independent carriers. A channel counter walks through the channels one per enabled clock. Each channel keeps its own phase accumulator in a small register file. On its turn, a channel's phase advances by three terms added together: its own frequency word, a signed frequency-modulation offset and a hop increment. The frequency word and the offset arrive on the input pins during that channel's cycle. The hop increment is shared by all channels.

The accumulated phase, shifted by a per-turn phase-modulation offset, addresses a quarter-wave sine table. The table gives a sine and a cosine sample. The samples leave interleaved in the same channel order, with a valid flag. A start marker tags the channel-0 sample of each group and an end marker tags the last channel's sample. A downstream stage splits the stream back into channels.

A bank of hop registers holds stored frequency offsets, written through an address/data/strobe port. A select input chooses the active entry at run time. Changing the selection changes only the increment and never the stored phase, so hopping between frequencies keeps the carrier phase continuous. A low clock enable freezes the whole sequence so that the interleaving stays aligned.

Top module: `tdm_osc`

## Requirements
- R1: The channel counter is 0 in reset. The inputs present at the first enabled rising edge after reset belong to channel 0, the next enabled edges to channels 1..NUM_CH-1, and after NUM_CH-1 the counter wraps to 0, so each channel is served once every NUM_CH enabled cycles.
- R2: On its turn, a channel's stored phase becomes old phase + inc_in + fm_in (sign-extended to ACC_W) + active hop increment, modulo 2^ACC_W. Every channel keeps its own stored phase.
- R3: The phase sent to the table is the new stored phase plus pm_in × 2^(ACC_W−PM_W), modulo 2^ACC_W. The modulation offset never enters the stored phase.
- R4: The table address a is the top 6 bits of that phase. sin_out is within 2 LSB of 2047·sin(2π(a+0.5)/64), and cos_out is the same function at address (a+16) mod 64. Both are 12-bit two's complement.
- R5: A sample for inputs taken at enabled edge E appears after the next enabled edge. out_valid is 0 until the first sample and then stays 1.
- R6: out_sop is 1 exactly with channel-0 samples and out_eop is 1 exactly with channel NUM_CH-1 samples (both on every sample when NUM_CH is 1).
- R7: With hop_we high at a rising edge, hop_wdata is stored in entry hop_addr. A write with hop_addr ≥ HOP_N is ignored. Selecting an index ≥ HOP_N gives a zero hop increment.
- R8: hop_sel is sampled at every rising edge, whatever ce is, and the chosen entry is used from the following edge on. A change of selection alters only the increment, and the stored phases carry on without a jump.
- R9: While ce is low, the channel counter, the stored phases and all output registers hold their values.
- R10: During reset, sin_out, cos_out, out_valid, out_sop and out_eop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for the channel sequence and datapath |
| inc_in | input | ACC_W | Frequency word of the current channel |
| fm_in | input | FM_W | Signed frequency offset of the current channel |
| pm_in | input | PM_W | Phase offset of the current channel, aligned to the phase MSBs |
| hop_we | input | 1 | Write strobe for the hop bank |
| hop_addr | input | HOP_AW | Hop bank entry to write |
| hop_wdata | input | ACC_W | Hop increment to store |
| hop_sel | input | HOP_AW | Active hop bank entry |
| sin_out | output | 12 | Sine sample, two's complement |
| cos_out | output | 12 | Cosine sample, two's complement |
| out_valid | output | 1 | Sample outputs hold a computed sample |
| out_sop | output | 1 | Sample belongs to channel 0 |
| out_eop | output | 1 | Sample belongs to the last channel |

## Verification
A sample is due two enabled edges after its inputs are taken: one edge for the phase stage and one for the table stage. A hop selection takes effect one edge after it is sampled, and a bank write takes effect at the edge where it happens. The bench keeps a cycle model with the same two stages, a registered selection and a per-channel phase array. It advances this model at each rising edge using the inputs it drove on the previous falling edge. It compares the outputs at the following falling edge, so each result is checked in exactly the cycle it becomes due. Random frequency words, offsets, selections, writes and enable gaps are mixed with directed hop toggling, out-of-range writes, phase-offset sweeps and enable-low holds.

// File: rtl/tdm_osc_pkg.sv
`timescale 1ns/1ps
package tdm_osc_pkg;
   localparam int WAVE_W = 12;
   localparam int LUT_AW = 6;

   // first quadrant magnitudes at (i+0.5)/64 of a turn, full scale 2047
   function automatic logic [WAVE_W-2:0] quarter_mag(input logic [3:0] i);
      case (i)
         4'd0:  return 11'd100;
         4'd1:  return 11'd300;
         4'd2:  return 11'd497;
         4'd3:  return 11'd690;
         4'd4:  return 11'd875;
         4'd5:  return 11'd1052;
         4'd6:  return 11'd1219;
         4'd7:  return 11'd1375;
         4'd8:  return 11'd1517;
         4'd9:  return 11'd1644;
         4'd10: return 11'd1756;
         4'd11: return 11'd1850;
         4'd12: return 11'd1927;
         4'd13: return 11'd1986;
         4'd14: return 11'd2025;
         default: return 11'd2045;
      endcase
   endfunction

   function automatic logic signed [WAVE_W-1:0] wave_at(input logic [LUT_AW-1:0] a);
      logic [3:0]        idx;
      logic [WAVE_W-1:0] m;
      idx = a[4] ? ~a[3:0] : a[3:0];
      m   = {1'b0, quarter_mag(idx)};
      return a[5] ? -$signed(m) : $signed(m);
   endfunction
endpackage

// File: rtl/tdm_osc_chanseq.sv
`timescale 1ns/1ps
module tdm_osc_chanseq #(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   output logic [CH_W-1:0] ch,
   output logic            ch_first,
   output logic            ch_last
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   generate
      if (NUM_CH == 1) begin : g_single
         wire unused_single = &{1'b0, clk, rst_n, ce};
         assign ch = '0;
      end else begin : g_multi
         logic [CH_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (ce) begin
               if (cnt_q == LAST_CH)  cnt_q <= '0;
               else                   cnt_q <= cnt_q + 1'b1;
            end
         end
         assign ch = cnt_q;

         // R1
         chan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce && ch == LAST_CH) |=> (ch == '0));
      end
   endgenerate

   assign ch_first = (ch == '0);
   assign ch_last  = (ch == LAST_CH);

   // R1
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch <= LAST_CH);
   // R9
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(ch));
endmodule

// File: rtl/tdm_osc_hopbank.sv
`timescale 1ns/1ps
module tdm_osc_hopbank #(
   parameter int HOP_N  = 12,
   parameter int HOP_AW = 4,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [HOP_AW-1:0] addr,
   input  logic [ACC_W-1:0]  wdata,
   input  logic [HOP_AW-1:0] sel,
   output logic [ACC_W-1:0]  hop_inc
);
   localparam logic [HOP_AW:0] N_V = (HOP_AW+1)'(HOP_N);

   logic [ACC_W-1:0] bank [HOP_N];
   logic [ACC_W-1:0] rd;

   always_comb begin
      rd = '0;
      for (int i = 0; i < HOP_N; i++)
         if (sel == HOP_AW'(i)) rd = bank[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HOP_N; i++) bank[i] <= '0;
         hop_inc <= '0;
      end else begin
         hop_inc <= rd;
         for (int i = 0; i < HOP_N; i++)
            if (we && addr == HOP_AW'(i)) bank[i] <= wdata;
      end
   end

   // R7
   hop_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel} >= N_V) |=> (hop_inc == '0));
endmodule

// File: rtl/tdm_osc_phase.sv
`timescale 1ns/1ps
module tdm_osc_phase #(
   parameter int NUM_CH = 4,
   parameter int ACC_W  = 16,
   parameter int FM_W   = 8,
   parameter int PM_W   = 8,
   parameter int LUT_AW = 6,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [CH_W-1:0]   ch,
   input  logic [ACC_W-1:0]  inc_in,
   input  logic [FM_W-1:0]   fm_in,
   input  logic [PM_W-1:0]   pm_in,
   input  logic [ACC_W-1:0]  hop_inc,
   output logic [LUT_AW-1:0] lut_addr
);
   logic [ACC_W-1:0] acc [NUM_CH];
   logic [ACC_W-1:0] fm_ext, pm_ext, step, acc_nxt, ph_full;
   logic [ACC_W-LUT_AW-1:0] frac_unused;

   assign fm_ext      = {{(ACC_W-FM_W){fm_in[FM_W-1]}}, fm_in};
   assign pm_ext      = {pm_in, {(ACC_W-PM_W){1'b0}}};
   assign step        = inc_in + fm_ext + hop_inc;
   assign acc_nxt     = acc[ch] + step;
   assign ph_full     = acc_nxt + pm_ext;
   assign frac_unused = ph_full[ACC_W-LUT_AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) acc[i] <= '0;
         lut_addr <= '0;
      end else if (ce) begin
         acc[ch]  <= acc_nxt;
         lut_addr <= ph_full[ACC_W-1 -: LUT_AW];
      end
   end

   // R9
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(lut_addr));
endmodule

// File: rtl/tdm_osc_wave.sv
`timescale 1ns/1ps
module tdm_osc_wave
   import tdm_osc_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ce,
   input  logic [LUT_AW-1:0]        addr,
   output logic signed [WAVE_W-1:0] sin_o,
   output logic signed [WAVE_W-1:0] cos_o
);
   localparam logic [LUT_AW-1:0] QTR = LUT_AW'(1 << (LUT_AW - 2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_o <= '0;
         cos_o <= '0;
      end else if (ce) begin
         sin_o <= wave_at(addr);
         cos_o <= wave_at(addr + QTR);
      end
   end

   // R4
   wave_zero_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> (sin_o != '0 && cos_o != '0));
endmodule

// File: rtl/tdm_osc.sv
`timescale 1ns/1ps
module tdm_osc
   import tdm_osc_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ACC_W  = 16,
   parameter int FM_W   = 8,
   parameter int PM_W   = 8,
   parameter int HOP_N  = 12,
   parameter int HOP_AW = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ce,
   input  logic [ACC_W-1:0]         inc_in,
   input  logic [FM_W-1:0]          fm_in,
   input  logic [PM_W-1:0]          pm_in,
   input  logic                     hop_we,
   input  logic [HOP_AW-1:0]        hop_addr,
   input  logic [ACC_W-1:0]         hop_wdata,
   input  logic [HOP_AW-1:0]        hop_sel,
   output logic signed [WAVE_W-1:0] sin_out,
   output logic signed [WAVE_W-1:0] cos_out,
   output logic                     out_valid,
   output logic                     out_sop,
   output logic                     out_eop
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("tdm_osc: NUM_CH must lie in 1..8");
      end
      if (HOP_N < 1 || HOP_N > 16 || HOP_N > (1 << HOP_AW)) begin : g_bad_hop
         $error("tdm_osc: HOP_N must lie in 1..16 and fit HOP_AW");
      end
      if (FM_W >= ACC_W || PM_W >= ACC_W || ACC_W <= LUT_AW) begin : g_bad_w
         $error("tdm_osc: modulation widths must be below ACC_W");
      end
   endgenerate

   logic [CH_W-1:0]   ch;
   logic              ch_first, ch_last;
   logic [ACC_W-1:0]  hop_inc;
   logic [LUT_AW-1:0] lut_addr;
   logic              vld1, sop1, eop1;

   tdm_osc_chanseq #(.NUM_CH(NUM_CH)) u_seq (
      .clk(clk), .rst_n(rst_n), .ce(ce),
      .ch(ch), .ch_first(ch_first), .ch_last(ch_last));

   tdm_osc_hopbank #(.HOP_N(HOP_N), .HOP_AW(HOP_AW), .ACC_W(ACC_W)) u_hop (
      .clk(clk), .rst_n(rst_n), .we(hop_we), .addr(hop_addr),
      .wdata(hop_wdata), .sel(hop_sel), .hop_inc(hop_inc));

   tdm_osc_phase #(.NUM_CH(NUM_CH), .ACC_W(ACC_W), .FM_W(FM_W),
                   .PM_W(PM_W), .LUT_AW(LUT_AW)) u_phase (
      .clk(clk), .rst_n(rst_n), .ce(ce), .ch(ch), .inc_in(inc_in),
      .fm_in(fm_in), .pm_in(pm_in), .hop_inc(hop_inc), .lut_addr(lut_addr));

   tdm_osc_wave u_wave (
      .clk(clk), .rst_n(rst_n), .ce(ce), .addr(lut_addr),
      .sin_o(sin_out), .cos_o(cos_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld1 <= 1'b0; sop1 <= 1'b0; eop1 <= 1'b0;
         out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0;
      end else if (ce) begin
         vld1      <= 1'b1;
         sop1      <= ch_first;
         eop1      <= ch_last;
         out_valid <= vld1;
         out_sop   <= sop1;
         out_eop   <= eop1;
      end
   end

   // R5
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> out_valid);
   // R6
   sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);
   // R6
   eop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> out_valid);
   // R6
   sop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (NUM_CH > 1 && ce && out_sop) |=> !out_sop);
   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(sin_out) && $stable(cos_out) && $stable(out_valid)
               && $stable(out_sop) && $stable(out_eop)));
endmodule

// File: tb/tdm_osc_tb.sv
`timescale 1ns/1ps
module tdm_osc_tb_top;
   localparam int NCH = 4, AW = 16, FW = 8, PW = 8, HN = 12, HAW = 4;

   logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
   logic [AW-1:0]  inc_in = '0, hop_wdata = '0;
   logic [FW-1:0]  fm_in = '0;
   logic [PW-1:0]  pm_in = '0;
   logic           hop_we = 1'b0;
   logic [HAW-1:0] hop_addr = '0, hop_sel = '0;
   logic signed [11:0] sin_out, cos_out;
   logic out_valid, out_sop, out_eop;

   tdm_osc #(.NUM_CH(NCH), .ACC_W(AW), .FM_W(FW), .PM_W(PW),
             .HOP_N(HN), .HOP_AW(HAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .inc_in(inc_in), .fm_in(fm_in),
      .pm_in(pm_in), .hop_we(hop_we), .hop_addr(hop_addr),
      .hop_wdata(hop_wdata), .hop_sel(hop_sel), .sin_out(sin_out),
      .cos_out(cos_out), .out_valid(out_valid), .out_sop(out_sop),
      .out_eop(out_eop));

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model
   int m_ch = 0;
   logic [AW-1:0] m_acc [NCH];
   logic [AW-1:0] m_hop [16];
   logic [AW-1:0] m_hopq = '0;
   logic [5:0] s1_a = '0, s2_a = '0;
   bit s1_v = 0, s1_s = 0, s1_e = 0, s2_v = 0, s2_s = 0, s2_e = 0;

   task automatic chk(bit ok, string msg, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
      end
   endtask

   function automatic real wave_ref(int a);
      return 2047.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 64.0);
   endfunction

   task automatic chk_wave(string msg, logic signed [11:0] act, int a);
      real e;
      e = wave_ref(a);
      chk(($itor(act) - e) <= 2.0 && (e - $itor(act)) <= 2.0, msg,
          int'(act), $rtoi(e));
   endtask

   task automatic model_edge();
      logic [AW-1:0] nacc, ph, nhq;
      if (ce) begin
         s2_v = s1_v; s2_s = s1_s; s2_e = s1_e; s2_a = s1_a;
         nacc = m_acc[m_ch] + inc_in + {{(AW-FW){fm_in[FW-1]}}, fm_in} + m_hopq;
         ph   = nacc + {pm_in, 8'h00};
         s1_a = ph[AW-1 -: 6];
         s1_v = 1; s1_s = (m_ch == 0); s1_e = (m_ch == NCH-1);
         m_acc[m_ch] = nacc;
         m_ch = (m_ch + 1) % NCH;
      end
      nhq = (int'(hop_sel) < HN) ? m_hop[hop_sel] : '0;
      if (hop_we && int'(hop_addr) < HN) m_hop[hop_addr] = hop_wdata;
      m_hopq = nhq;
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(out_valid == s2_v, {tag, " R5 valid"}, out_valid, s2_v);
      if (s2_v) begin
         chk(out_sop == s2_s, {tag, " R6 sop"}, out_sop, s2_s);
         chk(out_eop == s2_e, {tag, " R6 eop"}, out_eop, s2_e);
         chk_wave({tag, " R4 sine"}, sin_out, int'(s2_a));
         chk_wave({tag, " R4 cosine"}, cos_out, (int'(s2_a) + 16) % 64);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL R5 watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic signed [11:0] hs, hc;
      logic hv;
      void'($urandom(32'd20240917));
      for (int i = 0; i < NCH; i++) m_acc[i] = '0;
      for (int i = 0; i < 16; i++) m_hop[i] = '0;

      repeat (3) @(negedge clk);
      chk(sin_out == 0, "R10 reset sin", sin_out, 0);
      chk(cos_out == 0, "R10 reset cos", cos_out, 0);
      chk(out_valid == 0, "R10 reset valid", out_valid, 0);
      chk(out_sop == 0, "R10 reset sop", out_sop, 0);
      chk(out_eop == 0, "R10 reset eop", out_eop, 0);

      // R1: channel 0 taken on the first enabled edge after reset
      rst_n = 1'b1; ce = 1'b1;
      for (int k = 0; k < 12; k++) begin
         inc_in = AW'($urandom); fm_in = FW'($urandom);
         step("R1 start");
      end

      // R7: fill the hop bank
      for (int i = 0; i < HN; i++) begin
         hop_we = 1'b1; hop_addr = HAW'(i); hop_wdata = AW'($urandom);
         inc_in = AW'($urandom);
         step("R7 fill");
      end
      hop_we = 1'b0;

      // R2: random mix with enable gaps, selections and writes
      for (int k = 0; k < 500; k++) begin
         ce = ($urandom % 10) != 0;
         inc_in = AW'($urandom); fm_in = FW'($urandom); pm_in = PW'($urandom);
         hop_we = ($urandom % 8) == 0; hop_addr = HAW'($urandom);
         hop_wdata = AW'($urandom); hop_sel = HAW'($urandom);
         step("R2 random");
      end
      ce = 1'b1; hop_we = 1'b0;

      // R8: toggle between two stored hop increments
      inc_in = '0; fm_in = '0; pm_in = '0;
      hop_we = 1'b1; hop_addr = 4'd2; hop_wdata = 16'h0400; step("R8 setup");
      hop_addr = 4'd5; hop_wdata = 16'h1000; step("R8 setup");
      hop_we = 1'b0;
      for (int k = 0; k < 60; k++) begin
         hop_sel = ((k / 7) % 2) != 0 ? 4'd5 : 4'd2;
         step("R8 hop");
      end

      // R9: enable low holds every output
      hs = sin_out; hc = cos_out; hv = out_valid;
      ce = 1'b0;
      for (int k = 0; k < 6; k++) begin
         inc_in = AW'($urandom); pm_in = PW'($urandom);
         step("R9 hold");
         chk(sin_out == hs, "R9 sin held", sin_out, hs);
         chk(cos_out == hc, "R9 cos held", cos_out, hc);
         chk(out_valid == hv, "R9 valid held", out_valid, hv);
      end
      ce = 1'b1;

      // R7: write beyond the bank is ignored and out-of-range select is zero
      hop_we = 1'b1; hop_addr = 4'd13; hop_wdata = 16'h4000; inc_in = '0;
      step("R7 oob");
      hop_we = 1'b0; hop_sel = 4'd13;
      for (int k = 0; k < 16; k++) step("R7 oob");

      // R3: phase offset sweep with a frozen phase
      for (int k = 0; k < 40; k++) begin
         pm_in = PW'($urandom);
         step("R3 pm");
      end

      // R2: negative frequency offsets only
      pm_in = '0;
      for (int k = 0; k < 40; k++) begin
         fm_in = 8'h80 | FW'($urandom);
         step("R2 fm");
      end

      finish_run();
   end
endmodule